// File: doc/BRIEF.md
# Window-Rule Synaptic Weight Updater

This block keeps the synaptic weights that feed one output neuron, one 16-bit unsigned fraction per input line. Each input line has an age counter driven by a millisecond tick, so the block knows whether that input fired recently. When the neuron fires, a sweep visits every synapse in turn. Synapses whose input fired inside the recent window are strengthened. All the others are weakened. The size of each step shrinks exponentially as the weight nears the bound it is moving toward. The exponential factor is read from a 64-entry table that is computed when the design elaborates.

Device spread is modelled with a pair of step constants for each synapse, one for strengthening and one for weakening, which can be reloaded at any time. A constant of zero freezes that synapse in that direction. An optional disturb mode adds a small fraction of the strengthening step on every input spike. A neuron spike that arrives during a sweep is held in a one-deep flag. Further spikes are dropped and counted.

Top module: `stdp_updater`

## Requirements
- R1: After reset, busy, done and the drop count are 0, every step-up constant is 655 and every step-down constant is 328. Weight i starts at 30720 + ((i*2405) mod 4096).
- R2: Input spikes on their own, with disturb mode off, leave every weight unchanged.
- R3: An input is "recent" when fewer than 25 ticks have passed since its last spike. Each tick adds one to the age, which saturates at 25. An input spike in the same cycle as the accepted neuron spike counts as recent. Recency is sampled in the cycle the sweep starts. Recent synapses are strengthened and the others are weakened.
- R4: Strengthening adds step = (alpha_up * F(w[15:10])) >> 15 and saturates at 65535.
- R5: Weakening subtracts step = (alpha_down * F((~w)[15:10])) >> 15. The weight never drops below 7, and a result below 7 becomes 7.
- R6: F(0) = 32768 and F(k) = floor(F(k-1) * 62535 / 65536). The table approximates exp(-3k/64).
- R7: A configuration write sets both step constants of one synapse. A constant of 0 leaves that synapse unchanged in that direction.
- R8: busy rises in the cycle after an accepted neuron spike and stays high for 16 cycles. During those cycles synapse k is written at the k-th edge. done pulses for one cycle after the last write.
- R9: A neuron spike during a sweep sets a one-deep pending flag, and the pending flag starts another sweep once the block is idle. Each further spike while the flag is set adds 1 to the drop count, which saturates.
- R10: With disturb mode on, each input spike adds floor(step_up * eps / 256) to that synapse, using the strengthening step of its current weight. The addition saturates and is applied in idle cycles, lowest index first.
- R11: The weight read port is combinational: rd_weight follows rd_idx with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ms_tick | input | 1 | One-cycle millisecond tick that ages the inputs |
| in_spike | input | 16 | Input spike vector, one bit per synapse |
| out_spike | input | 1 | Output neuron spike strobe |
| disturb_en | input | 1 | Enables read-disturb increments |
| disturb_eps | input | 8 | Disturb fraction in units of 1/256 |
| cfg_we | input | 1 | Writes both step constants of one synapse |
| cfg_idx | input | 4 | Synapse selected for the configuration write |
| cfg_alpha_p | input | 16 | Step-up constant (Q16 fraction) |
| cfg_alpha_m | input | 16 | Step-down constant (Q16 fraction) |
| rd_idx | input | 4 | Synapse selected for reading |
| rd_weight | output | 16 | Weight of the selected synapse |
| busy | output | 1 | A sweep is in progress |
| done | output | 1 | One-cycle pulse at the end of a sweep |
| drop_cnt | output | 8 | Saturating count of dropped neuron spikes |

## Verification
A corrupted age counter or recency snapshot flips the direction of one synapse's step. That shows at the read port as soon as the next sweep ends, at most 17 cycles after the neuron spike. An error in the factor table or the step arithmetic makes a weight differ from the bench's step-by-step model on the first affected update, and repeated saturating sweeps expose faults at the bounds. A sweep-index or pending-flag fault shows within one sweep as a wrong busy length, a missing or extra done pulse, or a half-written weight bank read in the middle of a sweep.

// File: rtl/stdp_pkg.sv
package stdp_pkg;

  typedef enum logic [1:0] {
    UPD_INC  = 2'd0,
    UPD_DEC  = 2'd1,
    UPD_DIST = 2'd2
  } upd_kind_e;

  // Soft-bound factor for table entry k: start at one half in the given
  // fixed-point width and multiply by a ratio (Q16) k times, truncating.
  function automatic int exp_entry(input int k, input int ratio_q16, input int fw);
    longint v;
    v = longint'(1) << (fw - 1);
    for (int j = 0; j < k; j++) begin
      v = (v * longint'(ratio_q16)) >>> 16;
    end
    return int'(v);
  endfunction

  // Spread of start-up weights around mid-range.
  function automatic int init_weight(input int i);
    return 30720 + ((i * 2405) % 4096);
  endfunction

endpackage

// File: rtl/stdp_exp_lut.sv
module stdp_exp_lut
  import stdp_pkg::*;
#(
  parameter int LB        = 6,
  parameter int FW        = 16,
  parameter int RATIO_Q16 = 62535
) (
  input  logic [LB-1:0] idx,
  output logic [FW-1:0] factor
);
  localparam int DEPTH = 2 ** LB;

  logic [FW-1:0] tbl [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    assign tbl[k] = FW'(exp_entry(k, RATIO_Q16, FW));
  end

  assign factor = tbl[idx];
endmodule

// File: rtl/stdp_step_unit.sv
module stdp_step_unit
  import stdp_pkg::*;
#(
  parameter int WW        = 16,
  parameter int AW        = 16,
  parameter int FW        = 16,
  parameter int LB        = 6,
  parameter int EW        = 8,
  parameter int GMIN      = 7,
  parameter int RATIO_Q16 = 62535
) (
  input  logic [WW-1:0] cur_w,
  input  upd_kind_e     kind,
  input  logic [AW-1:0] alpha_p,
  input  logic [AW-1:0] alpha_m,
  input  logic [EW-1:0] eps,
  output logic [WW-1:0] new_w
);
  localparam int PW = AW + FW;
  localparam int SW = WW + 1;
  localparam int XW = WW + 2;

  logic [LB-1:0]    lut_idx;
  logic [FW-1:0]    factor;
  logic [AW-1:0]    alpha;
  logic [PW-1:0]    prod;
  logic [SW-1:0]    step;
  logic [SW-1:0]    step_amt;
  logic [SW+EW-1:0] scaled;
  logic [XW-1:0]    sum;
  logic [XW-1:0]    lim;

  stdp_exp_lut #(.LB(LB), .FW(FW), .RATIO_Q16(RATIO_Q16)) u_lut (
    .idx   (lut_idx),
    .factor(factor)
  );

  always_comb begin
    lut_idx  = (kind == UPD_DEC) ? ~cur_w[WW-1 -: LB] : cur_w[WW-1 -: LB];
    alpha    = (kind == UPD_DEC) ? alpha_m : alpha_p;
    prod     = PW'(alpha) * PW'(factor);
    step     = prod[FW-1 +: SW];
    scaled   = (SW+EW)'(step) * (SW+EW)'(eps);
    step_amt = (kind == UPD_DIST) ? scaled[EW +: SW] : step;
    sum      = {2'b00, cur_w} + {1'b0, step_amt};
    lim      = {1'b0, step} + XW'(GMIN);
    if (kind == UPD_DEC) begin
      if ({2'b00, cur_w} < lim) new_w = WW'(GMIN);
      else                      new_w = cur_w - step[WW-1:0];
    end else begin
      if (sum > XW'({WW{1'b1}}))  new_w = {WW{1'b1}};
      else if (sum < XW'(GMIN))   new_w = WW'(GMIN);
      else                        new_w = sum[WW-1:0];
    end
  end
endmodule

// File: rtl/stdp_age_track.sv
module stdp_age_track #(
  parameter int N   = 16,
  parameter int WIN = 25
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic [N-1:0] in_spike,
  output logic [N-1:0] recent
);
  localparam int AGW = $clog2(WIN + 1);

  for (genvar i = 0; i < N; i++) begin : g_age
    logic [AGW-1:0] age_q;
    logic [AGW-1:0] age_d;
    logic           age_en;

    always_comb begin
      age_en = in_spike[i] | (tick & (age_q != AGW'(WIN)));
      if (in_spike[i]) age_d = '0;
      else             age_d = age_q + 1'b1;
      recent[i] = in_spike[i] | (age_q < AGW'(WIN));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      age_q <= AGW'(WIN);
      else if (age_en) age_q <= age_d;
    end

    // R3
    age_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      age_q <= AGW'(WIN));
  end
endmodule

// File: rtl/stdp_sweep_ctrl.sv
module stdp_sweep_ctrl #(
  parameter int N  = 16,
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 out_spike,
  input  logic                 dist_any,
  output logic                 start,
  output logic                 busy,
  output logic                 done,
  output logic                 dist_slot,
  output logic [$clog2(N)-1:0] sweep_idx,
  output logic [DW-1:0]        drop_cnt
);
  localparam int IW = $clog2(N);

  typedef enum logic {ST_IDLE, ST_SWEEP} st_e;

  st_e           state_q, state_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          pend_q, pend_d;
  logic          done_q, done_d;
  logic [DW-1:0] drop_q, drop_d;
  logic          last;

  always_comb begin
    start   = (state_q == ST_IDLE) && (out_spike || pend_q);
    last    = (state_q == ST_SWEEP) && (idx_q == IW'(N - 1));
    state_d = state_q;
    idx_d   = idx_q;
    pend_d  = pend_q;
    drop_d  = drop_q;
    done_d  = last;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_SWEEP;
          idx_d   = '0;
          pend_d  = pend_q && out_spike;
        end
      end
      default: begin
        idx_d = idx_q + 1'b1;
        if (last) begin
          state_d = ST_IDLE;
          idx_d   = '0;
        end
        if (out_spike) begin
          if (!pend_q)                pend_d = 1'b1;
          else if (drop_q != '1)      drop_d = drop_q + 1'b1;
        end
      end
    endcase
    dist_slot = (state_q == ST_IDLE) && !start && dist_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
      drop_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      pend_q  <= pend_d;
      done_q  <= done_d;
      drop_q  <= drop_d;
    end
  end

  assign busy      = (state_q == ST_SWEEP);
  assign done      = done_q;
  assign sweep_idx = idx_q;
  assign drop_cnt  = drop_q;

  // R8
  order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(state_q == ST_SWEEP)) |-> (idx_q == IW'($past(idx_q) + 1'b1)));

  // R8
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy && $past(state_q == ST_SWEEP)));

  // R9
  drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_q != $past(drop_q)) |-> $past((state_q == ST_SWEEP) && out_spike && pend_q));
endmodule

// File: rtl/stdp_updater.sv
module stdp_updater
  import stdp_pkg::*;
#(
  parameter int N_IN      = 16,
  parameter int WW        = 16,
  parameter int AW        = 16,
  parameter int FW        = 16,
  parameter int EW        = 8,
  parameter int LB        = 6,
  parameter int WIN_MS    = 25,
  parameter int DW        = 8,
  parameter int GMIN      = 7,
  parameter int ALPHA_P0  = 655,
  parameter int ALPHA_M0  = 328,
  parameter int RATIO_Q16 = 62535,
  localparam int IW       = $clog2(N_IN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ms_tick,
  input  logic [N_IN-1:0] in_spike,
  input  logic            out_spike,
  input  logic            disturb_en,
  input  logic [EW-1:0]   disturb_eps,
  input  logic            cfg_we,
  input  logic [IW-1:0]   cfg_idx,
  input  logic [AW-1:0]   cfg_alpha_p,
  input  logic [AW-1:0]   cfg_alpha_m,
  input  logic [IW-1:0]   rd_idx,
  output logic [WW-1:0]   rd_weight,
  output logic            busy,
  output logic            done,
  output logic [DW-1:0]   drop_cnt
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [WW-1:0]   w_q  [N_IN];
  logic [WW-1:0]   w_d  [N_IN];
  logic [AW-1:0]   ap_q [N_IN];
  logic [AW-1:0]   am_q [N_IN];
  logic [N_IN-1:0] recent;
  logic [N_IN-1:0] snap_q;
  logic [N_IN-1:0] pend_q, pend_d;
  logic            start, dist_slot, dist_any, wr_en;
  logic [IW-1:0]   sweep_idx, dist_idx, sel_idx;
  upd_kind_e       kind;
  logic [WW-1:0]   cur_w, upd_w;

  stdp_age_track #(.N(N_IN), .WIN(WIN_MS)) u_age (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .tick    (ms_tick),
    .in_spike(in_spike),
    .recent  (recent)
  );

  stdp_sweep_ctrl #(.N(N_IN), .DW(DW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .out_spike(out_spike),
    .dist_any (dist_any),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .dist_slot(dist_slot),
    .sweep_idx(sweep_idx),
    .drop_cnt (drop_cnt)
  );

  stdp_step_unit #(
    .WW(WW), .AW(AW), .FW(FW), .LB(LB), .EW(EW), .GMIN(GMIN), .RATIO_Q16(RATIO_Q16)
  ) u_step (
    .cur_w  (cur_w),
    .kind   (kind),
    .alpha_p(ap_q[sel_idx]),
    .alpha_m(am_q[sel_idx]),
    .eps    (disturb_eps),
    .new_w  (upd_w)
  );

  // selection of the synapse served this cycle
  always_comb begin
    dist_idx = '0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (pend_q[i]) dist_idx = IW'(i);
    end
    dist_any = |pend_q;
    sel_idx  = busy ? sweep_idx : dist_idx;
    if (busy) kind = snap_q[sweep_idx] ? UPD_INC : UPD_DEC;
    else      kind = UPD_DIST;
    cur_w = w_q[sel_idx];
    wr_en = busy | dist_slot;
  end

  always_comb begin
    w_d = w_q;
    w_d[sel_idx] = upd_w;
    pend_d = pend_q;
    if (dist_slot) pend_d[dist_idx] = 1'b0;
    pend_d = pend_d | (in_spike & {N_IN{disturb_en}});
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      for (int i = 0; i < N_IN; i++) w_q[i] <= WW'(init_weight(i));
    end else if (wr_en) begin
      w_q <= w_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      for (int i = 0; i < N_IN; i++) begin
        ap_q[i] <= AW'(ALPHA_P0);
        am_q[i] <= AW'(ALPHA_M0);
      end
    end else if (cfg_we) begin
      ap_q[cfg_idx] <= cfg_alpha_p;
      am_q[cfg_idx] <= cfg_alpha_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)   snap_q <= '0;
    else if (start) snap_q <= recent;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) pend_q <= '0;
    else          pend_q <= pend_d;
  end

  assign rd_weight = w_q[rd_idx];

  // R5
  weight_floor_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    wr_en |-> (upd_w >= WW'(GMIN)));

  // R4
  inc_mono_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && kind != UPD_DEC) |-> (upd_w >= cur_w));

  // R5
  dec_mono_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && kind == UPD_DEC) |-> (upd_w <= cur_w));

  // R7
  alpha_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && kind == UPD_INC && ap_q[sel_idx] == '0) |-> (upd_w == cur_w));
endmodule

// File: tb/stdp_updater_test.sv
`timescale 1ns/1ps
module stdp_updater_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ms_tick;
  logic [15:0] in_spike;
  logic        out_spike;
  logic        disturb_en;
  logic [7:0]  disturb_eps;
  logic        cfg_we;
  logic [3:0]  cfg_idx;
  logic [15:0] cfg_alpha_p, cfg_alpha_m;
  logic [3:0]  rd_idx;
  logic [15:0] rd_weight;
  logic        busy, done;
  logic [7:0]  drop_cnt;

  int tests = 0;
  int fails = 0;
  int mw [16];
  int map [16];
  int mam [16];
  int mage [16];
  int drop_exp = 0;

  always #2 clk = ~clk;

  stdp_updater uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .in_spike(in_spike),
    .out_spike(out_spike), .disturb_en(disturb_en), .disturb_eps(disturb_eps),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_alpha_p(cfg_alpha_p),
    .cfg_alpha_m(cfg_alpha_m), .rd_idx(rd_idx), .rd_weight(rd_weight),
    .busy(busy), .done(done), .drop_cnt(drop_cnt)
  );

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // R6 table
  function automatic longint ftab(input int k);
    longint v = 32768;
    for (int j = 0; j < k; j++) v = (v * 62535) / 65536;
    return v;
  endfunction

  function automatic int step_of(input int w, input int alpha, input bit dec);
    int k = dec ? ((65535 - w) / 1024) : (w / 1024);
    return int'((longint'(alpha) * ftab(k)) / 32768);
  endfunction

  function automatic int sat_add(input int w, input int s);
    int r = w + s;
    if (r > 65535) r = 65535;
    if (r < 7) r = 7;
    return r;
  endfunction

  function automatic int floor_sub(input int w, input int s);
    return (w - s < 7) ? 7 : (w - s);
  endfunction

  task automatic model_sweep();
    for (int i = 0; i < 16; i++) begin
      if (mage[i] < 25) mw[i] = sat_add(mw[i], step_of(mw[i], map[i], 1'b0));
      else              mw[i] = floor_sub(mw[i], step_of(mw[i], mam[i], 1'b1));
    end
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < 16; i++) begin
      rd_idx = 4'(i);
      #0.1;
      chk(rd_weight == 16'(mw[i]), $sformatf("%s w[%0d]", tag, i), rd_weight, mw[i]);
    end
    @(negedge clk);
  endtask

  task automatic pulse_in(input logic [15:0] v);
    in_spike = v;
    @(negedge clk);
    in_spike = '0;
    for (int i = 0; i < 16; i++) if (v[i]) mage[i] = 0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      ms_tick = 1'b1;
      repeat (n) @(negedge clk);
      ms_tick = 1'b0;
      for (int i = 0; i < 16; i++) mage[i] = (mage[i] + n > 25) ? 25 : mage[i] + n;
    end
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    if (n >= 100) chk(1'b0, {tag, " done timeout"}, n, 17);
  endtask

  task automatic fire(input logic [15:0] same_vec);
    in_spike  = same_vec;
    out_spike = 1'b1;
    @(negedge clk);
    in_spike  = '0;
    out_spike = 1'b0;
    for (int i = 0; i < 16; i++) if (same_vec[i]) mage[i] = 0;
    wait_done("R8");
    @(negedge clk);
    model_sweep();
  endtask

  task automatic cfg(input int idx, input int ap, input int am);
    cfg_we = 1'b1; cfg_idx = 4'(idx);
    cfg_alpha_p = 16'(ap); cfg_alpha_m = 16'(am);
    @(negedge clk);
    cfg_we = 1'b0;
    map[idx] = ap; mam[idx] = am;
  endtask

  initial begin
    int bc;
    int dn;
    int old8;
    int w0;
    int w9;
    int w10;
    void'($urandom(32'h5EED));
    rst_n = 1'b0; ms_tick = 0; in_spike = '0; out_spike = 0;
    disturb_en = 0; disturb_eps = 8'd26; cfg_we = 0; cfg_idx = '0;
    cfg_alpha_p = '0; cfg_alpha_m = '0; rd_idx = '0;
    for (int i = 0; i < 16; i++) begin
      mw[i] = 30720 + ((i * 2405) % 4096);
      map[i] = 655; mam[i] = 328; mage[i] = 25;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(drop_cnt == 8'd0, "R1 drop_cnt", drop_cnt, 0);
    check_all("R1 init");

    // R11 combinational read
    rd_idx = 4'd5; #0.3;
    chk(rd_weight == 16'(mw[5]), "R11 read 5", rd_weight, mw[5]);
    rd_idx = 4'd6; #0.3;
    chk(rd_weight == 16'(mw[6]), "R11 read 6", rd_weight, mw[6]);
    @(negedge clk);

    // R2 input spikes alone
    pulse_in(16'hA5A5);
    ticks(3);
    pulse_in(16'h0F0F);
    repeat (5) @(negedge clk);
    check_all("R2 no change");

    // R8 sweep timing and index order, R3 direction
    old8 = mw[8];
    model_sweep();
    out_spike = 1'b1;
    @(negedge clk);
    out_spike = 1'b0;
    chk(busy == 1'b1, "R8 busy after accept", busy, 1);
    bc = 0;
    while (busy && bc < 40) begin
      bc++;
      if (bc == 9) begin
        rd_idx = 4'd7; #0.4;
        chk(rd_weight == 16'(mw[7]), "R8 w[7] written mid-sweep", rd_weight, mw[7]);
        rd_idx = 4'd8; #0.4;
        chk(rd_weight == 16'(old8), "R8 w[8] not yet written", rd_weight, old8);
      end
      @(negedge clk);
    end
    chk(bc == 16, "R8 busy length", bc, 16);
    chk(done == 1'b1, "R8 done pulse", done, 1);
    @(negedge clk);
    chk(done == 1'b0, "R8 done one cycle", done, 0);
    check_all("R3/R4/R5/R6 first sweep");

    // R3 window boundary: 24 ticks recent, 25 ticks not
    ticks(30);
    pulse_in(16'h0008);
    ticks(1);
    pulse_in(16'h0004);
    ticks(24);
    w0 = mw[2];
    old8 = mw[3];
    fire(16'h0000);
    chk(mw[2] > w0, "R3 model age 24 strengthens", mw[2], w0 + 1);
    chk(mw[3] < old8, "R3 model age 25 weakens", mw[3], old8 - 1);
    check_all("R3 boundary");

    // R3 spike in the same cycle as the neuron spike
    ticks(30);
    fire(16'h0010);
    check_all("R3 same-cycle spike");

    // R7 zero step constants
    cfg(9, 0, 0);
    cfg(10, 0, 328);
    w9 = mw[9]; w10 = mw[10];
    pulse_in(16'h0600);
    fire(16'h0000);
    ticks(30);
    fire(16'h0000);
    rd_idx = 4'd9; #0.2;
    chk(rd_weight == 16'(w9), "R7 alpha 0 synapse frozen", rd_weight, w9);
    rd_idx = 4'd10; #0.2;
    chk(rd_weight != 16'(w10), "R7 nonzero step-down still acts", rd_weight, mw[10]);
    @(negedge clk);
    check_all("R7");

    // R4/R5 saturation at both bounds
    cfg(3, 65535, 65535);
    cfg(5, 65535, 65535);
    for (int k = 0; k < 40; k++) begin
      pulse_in(16'h0008);
      fire(16'h0000);
    end
    rd_idx = 4'd3; #0.2;
    chk(rd_weight == 16'hFFFF, "R4 saturates at top", rd_weight, 65535);
    rd_idx = 4'd5; #0.2;
    chk(rd_weight == 16'd7, "R5 floor at 7", rd_weight, 7);
    @(negedge clk);
    check_all("R4/R5 bounds");
    cfg(3, 655, 328);
    cfg(5, 655, 328);

    // R9 pending flag and dropped spikes
    pulse_in(16'h3000);
    out_spike = 1'b1; @(negedge clk); out_spike = 1'b0;
    @(negedge clk);
    out_spike = 1'b1; @(negedge clk); out_spike = 1'b0;
    @(negedge clk);
    out_spike = 1'b1; @(negedge clk); out_spike = 1'b0;
    @(negedge clk);
    out_spike = 1'b1; @(negedge clk); out_spike = 1'b0;
    dn = 0;
    for (int k = 0; k < 60; k++) begin
      if (done) dn++;
      @(negedge clk);
    end
    drop_exp += 2;
    model_sweep();
    model_sweep();
    chk(dn == 2, "R9 two sweeps run", dn, 2);
    chk(drop_cnt == 8'(drop_exp), "R9 drop count", drop_cnt, drop_exp);
    check_all("R9 queued sweep");

    // R10 read disturb
    disturb_en = 1'b1;
    disturb_eps = 8'd26;
    pulse_in(16'h7000);
    repeat (5) @(negedge clk);
    disturb_en = 1'b0;
    for (int i = 12; i < 15; i++)
      mw[i] = sat_add(mw[i], (step_of(mw[i], map[i], 1'b0) * 26) / 256);
    check_all("R10 disturb");
    pulse_in(16'h0001);
    repeat (3) @(negedge clk);
    check_all("R10 disturb off");

    // R3/R4/R5/R7 random patterns
    for (int it = 0; it < 30; it++) begin
      if (($urandom % 4) == 0) cfg(int'($urandom % 16), int'($urandom % 3000), int'($urandom % 3000));
      pulse_in(16'($urandom));
      ticks(int'($urandom % 31));
      if (($urandom % 2) == 0) pulse_in(16'($urandom));
      fire(($urandom % 3) == 0 ? 16'($urandom) : 16'h0000);
      check_all($sformatf("R3/R4/R5 random %0d", it));
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule